// File: doc/BRIEF.md
# Sound Coprocessor Command/Data Mailbox

The mailbox links a host CPU to a sound coprocessor CPU. Each processor reaches it through its own I/O port decoder and single-cycle read and write strobes. The host posts a command byte and exchanges data bytes in both directions. Two flags report the state of the mailbox: a command flag and a data flag. Port accesses on either side set or clear these flags as a side effect, so each side can poll the flags and act when the other side has posted something.

A host control register drives three outputs toward the coprocessor: a reset request level, a one-cycle NMI pulse and an LED toggle. The coprocessor also drives the LED level directly from its own port. It owns two legacy ports that load a flag from a bit of a page register or of a volume register. Only the single bit of each register that a legacy port uses is kept. Read data is combinational and valid during the read strobe. A read shows the state before that read's own side effect, and every flag change takes effect at the next clock edge.

Top module: `snd_mailbox`

## Requirements
- R1: A host write to address 0xBB stores the command byte and sets the command flag. A coprocessor read of port 0x01 returns that byte.
- R2: A host read of 0xBB returns a status byte with the command flag in bit 0, the data flag in bit 7 and zeros in bits 6..1. A coprocessor read of port 0x04 returns the same byte and has no side effect.
- R3: A host write to 0xB3 sets the data flag. A coprocessor read of port 0x02 returns that byte and clears the data flag.
- R4: A coprocessor write to port 0x03 sets the data flag. A host read of 0xB3 returns that byte and clears the data flag.
- R5: A coprocessor read or write of port 0x05 clears the command flag.
- R6: A coprocessor read or write of port 0x0A loads the data flag with the inverse of bit 0 of the page register, which is written at port 0x00.
- R7: A coprocessor read or write of port 0x0B loads the command flag with bit 5 of the volume register, which is written at port 0x09.
- R8: When a set and a clear of the same flag fall in the same cycle, from either side, the flag is set. This includes a legacy port that loads a 1 or a 0.
- R9: After reset both flags are 0, the LED is on (led_o = 1), and the reset and NMI outputs are 0.
- R10: A host write to 0x33 loads cp_rst_o from data bit 7. The output keeps that value until the next write to 0x33.
- R11: A host write to 0x33 with bit 6 set raises cp_nmi_o for exactly the next cycle.
- R12: A host write to 0x33 with bit 5 set toggles led_o. A coprocessor write to port 0x01 sets led_o to the inverse of data bit 0. If both happen in the same cycle, the coprocessor write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_addr_i | input | 8 | Host port address |
| h_wr_i | input | 1 | Host write strobe |
| h_rd_i | input | 1 | Host read strobe |
| h_wdata_i | input | 8 | Host write data |
| h_rdata_o | output | 8 | Host read data, zero when no decoded read |
| c_addr_i | input | 8 | Coprocessor port address |
| c_wr_i | input | 1 | Coprocessor write strobe |
| c_rd_i | input | 1 | Coprocessor read strobe |
| c_wdata_i | input | 8 | Coprocessor write data |
| c_rdata_o | output | 8 | Coprocessor read data, zero when no decoded read |
| cp_rst_o | output | 1 | Coprocessor reset request level |
| cp_nmi_o | output | 1 | Coprocessor NMI pulse |
| led_o | output | 1 | LED on when 1 |

## Verification
The bench tries every pairing of host and coprocessor operations that touch one flag in the same cycle. It runs each pairing from both initial flag values and with both values of the legacy source bit. A design that lets the clear win, or that treats a legacy load of 0 as stronger than a concurrent set, produces the wrong flag in those cells. The command byte is swept over all 256 values to catch a dropped or swapped data bit. The LED test drives a toggle and a direct coprocessor write in the same cycle, so a design that gives the toggle priority leaves the LED off. The NMI test checks the cycle after the pulse, which catches a pulse that is stretched or held.

// File: rtl/mb_pkg.sv
package mb_pkg;
  localparam int DW = 8;

  localparam logic [7:0] H_CMD = 8'hBB;
  localparam logic [7:0] H_DAT = 8'hB3;
  localparam logic [7:0] H_CTL = 8'h33;

  localparam logic [7:0] C_PAGE    = 8'h00;
  localparam logic [7:0] C_CMD_LED = 8'h01;
  localparam logic [7:0] C_DRD     = 8'h02;
  localparam logic [7:0] C_DWR     = 8'h03;
  localparam logic [7:0] C_STAT    = 8'h04;
  localparam logic [7:0] C_CLRC    = 8'h05;
  localparam logic [7:0] C_VOL4    = 8'h09;
  localparam logic [7:0] C_LEGA    = 8'h0A;
  localparam logic [7:0] C_LEGB    = 8'h0B;

  localparam int CF_POS   = 0;
  localparam int DF_POS   = 7;
  localparam int CTL_RST  = 7;
  localparam int CTL_NMI  = 6;
  localparam int CTL_LED  = 5;
  localparam int PAGE_POS = 0;
  localparam int VOL_POS  = 5;

  function automatic logic [DW-1:0] status_byte(input logic cf, input logic df);
    logic [DW-1:0] s;
    s = '0;
    s[CF_POS] = cf;
    s[DF_POS] = df;
    return s;
  endfunction
endpackage

// File: rtl/mb_flag.sv
module mb_flag #(
  parameter int NSET = 2,
  parameter int NCLR = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSET-1:0] set_i,
  input  logic [NCLR-1:0] clr_i,
  output logic            flag_o
);
  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (|set_i) flag_o <= 1'b1;
    else if (|clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/mb_host_port.sv
module mb_host_port
  import mb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          cflag_i,
  input  logic          dflag_i,
  input  logic [DW-1:0] c2h_i,
  output logic [DW-1:0] cmd_o,
  output logic [DW-1:0] h2c_o,
  output logic          cf_set_o,
  output logic          df_set_o,
  output logic          df_clr_o,
  output logic          rst_req_o,
  output logic          nmi_o,
  output logic          led_tgl_o
);
  logic wr_cmd, wr_dat, rd_cmd, rd_dat, wr_ctl;

  assign wr_cmd = wr_i && (addr_i == H_CMD);
  assign rd_cmd = rd_i && (addr_i == H_CMD);
  assign wr_dat = wr_i && (addr_i == H_DAT);
  assign rd_dat = rd_i && (addr_i == H_DAT);
  assign wr_ctl = wr_i && (addr_i == H_CTL);

  assign cf_set_o  = wr_cmd;
  assign df_set_o  = wr_dat;
  assign df_clr_o  = rd_dat;
  assign led_tgl_o = wr_ctl && wdata_i[CTL_LED];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o     <= '0;
      h2c_o     <= '0;
      rst_req_o <= 1'b0;
      nmi_o     <= 1'b0;
    end else begin
      if (wr_cmd) cmd_o <= wdata_i;
      if (wr_dat) h2c_o <= wdata_i;
      if (wr_ctl) rst_req_o <= wdata_i[CTL_RST];
      nmi_o <= wr_ctl && wdata_i[CTL_NMI];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_cmd)      rdata_o = status_byte(cflag_i, dflag_i);
    else if (rd_dat) rdata_o = c2h_i;
  end
endmodule

// File: rtl/mb_copro_port.sv
module mb_copro_port
  import mb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          cflag_i,
  input  logic          dflag_i,
  input  logic [DW-1:0] cmd_i,
  input  logic [DW-1:0] h2c_i,
  input  logic          led_tgl_i,
  output logic [DW-1:0] c2h_o,
  output logic          cf_set_o,
  output logic          cf_clr_o,
  output logic          df_set_o,
  output logic          df_clr_o,
  output logic          led_o,
  output logic          page_bit_o,
  output logic          vol_bit_o
);
  logic acc, acc_clrc, acc_lega, acc_legb, wr_dwr, rd_drd, wr_led;

  assign acc      = wr_i || rd_i;
  assign acc_clrc = acc && (addr_i == C_CLRC);
  assign acc_lega = acc && (addr_i == C_LEGA);
  assign acc_legb = acc && (addr_i == C_LEGB);
  assign wr_dwr   = wr_i && (addr_i == C_DWR);
  assign rd_drd   = rd_i && (addr_i == C_DRD);
  assign wr_led   = wr_i && (addr_i == C_CMD_LED);

  // legacy ports load a flag: loading 1 is a set, loading 0 is a clear
  assign df_set_o = wr_dwr || (acc_lega && !page_bit_o);
  assign df_clr_o = rd_drd || (acc_lega &&  page_bit_o);
  assign cf_set_o = acc_legb && vol_bit_o;
  assign cf_clr_o = acc_clrc || (acc_legb && !vol_bit_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c2h_o      <= '0;
      page_bit_o <= 1'b0;
      vol_bit_o  <= 1'b0;
      led_o      <= 1'b1;
    end else begin
      if (wr_dwr) c2h_o <= wdata_i;
      if (wr_i && addr_i == C_PAGE) page_bit_o <= wdata_i[PAGE_POS];
      if (wr_i && addr_i == C_VOL4) vol_bit_o  <= wdata_i[VOL_POS];
      if (wr_led)         led_o <= !wdata_i[0];
      else if (led_tgl_i) led_o <= !led_o;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        C_CMD_LED: rdata_o = cmd_i;
        C_DRD:     rdata_o = h2c_i;
        C_STAT:    rdata_o = status_byte(cflag_i, dflag_i);
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/snd_mailbox.sv
module snd_mailbox
  import mb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    h_addr_i,
  input  logic          h_wr_i,
  input  logic          h_rd_i,
  input  logic [DW-1:0] h_wdata_i,
  output logic [DW-1:0] h_rdata_o,
  input  logic [7:0]    c_addr_i,
  input  logic          c_wr_i,
  input  logic          c_rd_i,
  input  logic [DW-1:0] c_wdata_i,
  output logic [DW-1:0] c_rdata_o,
  output logic          cp_rst_o,
  output logic          cp_nmi_o,
  output logic          led_o
);
  logic          cmd_flag, dat_flag;
  logic [DW-1:0] cmd_q, h2c_q, c2h_q;
  logic          h_cf_set, h_df_set, h_df_clr, led_tgl;
  logic          c_cf_set, c_cf_clr, c_df_set, c_df_clr;
  logic          page_bit, vol_bit;

  mb_host_port u_host (
    .clk_i, .rst_ni,
    .addr_i(h_addr_i), .wr_i(h_wr_i), .rd_i(h_rd_i),
    .wdata_i(h_wdata_i), .rdata_o(h_rdata_o),
    .cflag_i(cmd_flag), .dflag_i(dat_flag), .c2h_i(c2h_q),
    .cmd_o(cmd_q), .h2c_o(h2c_q),
    .cf_set_o(h_cf_set), .df_set_o(h_df_set), .df_clr_o(h_df_clr),
    .rst_req_o(cp_rst_o), .nmi_o(cp_nmi_o), .led_tgl_o(led_tgl)
  );

  mb_copro_port u_copro (
    .clk_i, .rst_ni,
    .addr_i(c_addr_i), .wr_i(c_wr_i), .rd_i(c_rd_i),
    .wdata_i(c_wdata_i), .rdata_o(c_rdata_o),
    .cflag_i(cmd_flag), .dflag_i(dat_flag),
    .cmd_i(cmd_q), .h2c_i(h2c_q), .led_tgl_i(led_tgl),
    .c2h_o(c2h_q),
    .cf_set_o(c_cf_set), .cf_clr_o(c_cf_clr),
    .df_set_o(c_df_set), .df_clr_o(c_df_clr),
    .led_o(led_o), .page_bit_o(page_bit), .vol_bit_o(vol_bit)
  );

  mb_flag #(.NSET(2), .NCLR(1)) u_cflag (
    .clk_i, .rst_ni,
    .set_i({h_cf_set, c_cf_set}), .clr_i(c_cf_clr), .flag_o(cmd_flag)
  );

  mb_flag #(.NSET(2), .NCLR(2)) u_dflag (
    .clk_i, .rst_ni,
    .set_i({h_df_set, c_df_set}), .clr_i({h_df_clr, c_df_clr}), .flag_o(dat_flag)
  );
endmodule

// File: rtl/mb_checker.sv
module mb_checker
  import mb_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [7:0]    h_addr_i,
  input logic          h_wr_i,
  input logic          h_rd_i,
  input logic          h_wd7_i,
  input logic          h_wd6_i,
  input logic [DW-1:0] h_rdata_i,
  input logic [7:0]    c_addr_i,
  input logic          c_wr_i,
  input logic          c_rd_i,
  input logic          c_wd0_i,
  input logic          cp_rst_i,
  input logic          cp_nmi_i,
  input logic          led_i,
  input logic          cmd_flag_i,
  input logic          dat_flag_i,
  input logic          page_bit_i,
  input logic          vol_bit_i
);
  logic c_acc;
  assign c_acc = c_wr_i || c_rd_i;

  p_cmd_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_wr_i && h_addr_i == H_CMD) |=> cmd_flag_i);

  p_status_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_rd_i && h_addr_i == H_CMD) |->
      (h_rdata_i[0] == cmd_flag_i && h_rdata_i[7] == dat_flag_i && h_rdata_i[6:1] == 6'd0));

  p_host_dat_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_wr_i && h_addr_i == H_DAT) |=> dat_flag_i);

  p_copro_dat_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr_i && c_addr_i == C_DWR) |=> dat_flag_i);

  p_clrc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_acc && c_addr_i == C_CLRC && !(h_wr_i && h_addr_i == H_CMD)) |=> !cmd_flag_i);

  p_lega_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_acc && c_addr_i == C_LEGA && !(h_wr_i && h_addr_i == H_DAT) && !(h_rd_i && h_addr_i == H_DAT))
      |=> dat_flag_i == !$past(page_bit_i));

  p_legb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_acc && c_addr_i == C_LEGB && !(h_wr_i && h_addr_i == H_CMD))
      |=> cmd_flag_i == $past(vol_bit_i));

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_rd_i && h_addr_i == H_DAT && c_wr_i && c_addr_i == C_DWR) |=> dat_flag_i);

  p_rst_level_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_wr_i && h_addr_i == H_CTL) |=> cp_rst_i == $past(h_wd7_i));

  p_nmi_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_nmi_i |-> $past(h_wr_i && h_addr_i == H_CTL && h_wd6_i));

  p_led_wr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wr_i && c_addr_i == C_CMD_LED) |=> led_i == !$past(c_wd0_i));
endmodule

bind snd_mailbox mb_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .h_addr_i(h_addr_i), .h_wr_i(h_wr_i), .h_rd_i(h_rd_i),
  .h_wd7_i(h_wdata_i[7]), .h_wd6_i(h_wdata_i[6]), .h_rdata_i(h_rdata_o),
  .c_addr_i(c_addr_i), .c_wr_i(c_wr_i), .c_rd_i(c_rd_i), .c_wd0_i(c_wdata_i[0]),
  .cp_rst_i(cp_rst_o), .cp_nmi_i(cp_nmi_o), .led_i(led_o),
  .cmd_flag_i(cmd_flag), .dat_flag_i(dat_flag),
  .page_bit_i(page_bit), .vol_bit_i(vol_bit)
);

// File: tb/tb_snd_mailbox.sv
module tb_snd_mailbox;
  localparam time CLK_PERIOD = 10ns;

  localparam int NONE = 0, RD = 1, WR = 2;
  localparam logic [7:0] H_CMD = 8'hBB, H_DAT = 8'hB3, H_CTL = 8'h33;
  localparam logic [7:0] C_PAGE = 8'h00, C_CMD_LED = 8'h01, C_DRD = 8'h02, C_DWR = 8'h03;
  localparam logic [7:0] C_STAT = 8'h04, C_CLRC = 8'h05, C_VOL4 = 8'h09;
  localparam logic [7:0] C_LEGA = 8'h0A, C_LEGB = 8'h0B;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] h_addr = '0, h_wdata = '0, c_addr = '0, c_wdata = '0;
  logic       h_wr = 1'b0, h_rd = 1'b0, c_wr = 1'b0, c_rd = 1'b0;
  logic [7:0] h_rdata, c_rdata;
  logic       cp_rst, cp_nmi, led;
  logic [7:0] h_smp, c_smp;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snd_mailbox dut (
    .clk_i(clk), .rst_ni(rst_n),
    .h_addr_i(h_addr), .h_wr_i(h_wr), .h_rd_i(h_rd), .h_wdata_i(h_wdata), .h_rdata_o(h_rdata),
    .c_addr_i(c_addr), .c_wr_i(c_wr), .c_rd_i(c_rd), .c_wdata_i(c_wdata), .c_rdata_o(c_rdata),
    .cp_rst_o(cp_rst), .cp_nmi_o(cp_nmi), .led_o(led)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle on both sides; read data sampled mid-cycle, state settled on return
  task automatic cyc(input int hop, input logic [7:0] ha, input logic [7:0] hd,
                     input int cop, input logic [7:0] ca, input logic [7:0] cd);
    @(negedge clk);
    h_addr = ha; h_wdata = hd; h_rd = (hop == RD); h_wr = (hop == WR);
    c_addr = ca; c_wdata = cd; c_rd = (cop == RD); c_wr = (cop == WR);
    #1;
    h_smp = h_rdata; c_smp = c_rdata;
    @(posedge clk); #1;
    h_rd = 1'b0; h_wr = 1'b0; c_rd = 1'b0; c_wr = 1'b0;
  endtask

  task automatic hcyc(input int op, input logic [7:0] a, input logic [7:0] d);
    cyc(op, a, d, NONE, 8'h00, 8'h00);
  endtask

  task automatic ccyc(input int op, input logic [7:0] a, input logic [7:0] d);
    cyc(NONE, 8'h00, 8'h00, op, a, d);
  endtask

  function automatic logic [7:0] stat(input logic cf, input logic df);
    return {df, 6'b0, cf};
  endfunction

  task automatic cur_stat(output logic [7:0] s);
    ccyc(RD, C_STAT, 8'h00);
    s = c_smp;
  endtask

  initial begin
    logic [7:0] s;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9 reset state
    check("R9 led", {7'b0, led}, 8'h01);
    check("R9 rst", {7'b0, cp_rst}, 8'h00);
    check("R9 nmi", {7'b0, cp_nmi}, 8'h00);
    hcyc(RD, H_CMD, 8'h00);
    check("R9 host status", h_smp, 8'h00);

    // R1 full command sweep
    for (int v = 0; v < 256; v++) begin
      hcyc(WR, H_CMD, v[7:0]);
      ccyc(RD, C_CMD_LED, 8'h00);
      check("R1 cmd byte", c_smp, v[7:0]);
    end
    cur_stat(s);
    check("R1 cmd flag", s, stat(1'b1, 1'b0));

    // R2 all four flag combinations, both status views
    for (int k = 0; k < 4; k++) begin
      if (k[0]) hcyc(WR, H_CMD, 8'h11); else ccyc(WR, C_CLRC, 8'h00);
      if (k[1]) hcyc(WR, H_DAT, 8'h22); else ccyc(RD, C_DRD, 8'h00);
      hcyc(RD, H_CMD, 8'h00);
      check("R2 host status", h_smp, stat(k[0], k[1]));
      ccyc(RD, C_STAT, 8'h00);
      check("R2 copro status", c_smp, stat(k[0], k[1]));
      ccyc(RD, C_STAT, 8'h00);
      check("R2 status no side effect", c_smp, stat(k[0], k[1]));
    end

    // R3 host to coprocessor data
    for (int v = 0; v < 256; v += 17) begin
      hcyc(WR, H_DAT, v[7:0]);
      cur_stat(s);
      check("R3 df set", s[7:0] & 8'h80, 8'h80);
      ccyc(RD, C_DRD, 8'h00);
      check("R3 data", c_smp, v[7:0]);
      cur_stat(s);
      check("R3 df clear", s & 8'h80, 8'h00);
    end

    // R4 coprocessor to host data
    for (int v = 3; v < 256; v += 19) begin
      ccyc(WR, C_DWR, v[7:0]);
      hcyc(RD, H_CMD, 8'h00);
      check("R4 df set", h_smp & 8'h80, 8'h80);
      hcyc(RD, H_DAT, 8'h00);
      check("R4 data", h_smp, v[7:0]);
      hcyc(RD, H_CMD, 8'h00);
      check("R4 df clear", h_smp & 8'h80, 8'h00);
    end

    // R5 clear command by read and by write
    for (int op = RD; op <= WR; op++) begin
      hcyc(WR, H_CMD, 8'h5A);
      ccyc(op, C_CLRC, 8'hFF);
      cur_stat(s);
      check("R5 cf cleared", s & 8'h01, 8'h00);
    end

    // R6 R8 data flag: every host op x copro op x initial x page bit
    for (int p = 0; p < 2; p++)
      for (int init = 0; init < 2; init++)
        for (int hop = 0; hop < 3; hop++)
          for (int cop = 0; cop < 4; cop++) begin
            logic set, clr, exp;
            ccyc(WR, C_PAGE, {7'b0, p[0]} | 8'hF0);
            if (init != 0) hcyc(WR, H_DAT, 8'h00); else ccyc(RD, C_DRD, 8'h00);
            cyc(hop, H_DAT, 8'hC3, (cop == 3) ? (1 + (cop + p) % 2) : cop,
                (cop == 3) ? C_LEGA : ((cop == WR) ? C_DWR : C_DRD), 8'h3C);
            set = (hop == WR) || (cop == WR) || (cop == 3 && p == 0);
            clr = (hop == RD) || (cop == RD) || (cop == 3 && p == 1);
            exp = set ? 1'b1 : (clr ? 1'b0 : init[0]);
            cur_stat(s);
            check((cop == 3) ? "R6 legacy data flag" : "R8 data flag set wins", s & 8'h80, {exp, 7'b0});
          end

    // R7 R8 command flag: every host op x copro op x initial x volume bit
    for (int v = 0; v < 2; v++)
      for (int init = 0; init < 2; init++)
        for (int hop = 0; hop < 2; hop++)
          for (int cop = 0; cop < 4; cop++) begin
            logic set, clr, exp;
            ccyc(WR, C_VOL4, {2'b0, v[0], 5'b0} | 8'h0F);
            if (init != 0) hcyc(WR, H_CMD, 8'h00); else ccyc(WR, C_CLRC, 8'h00);
            cyc((hop != 0) ? WR : NONE, H_CMD, 8'h77, (cop == 3) ? WR : cop,
                (cop == 3) ? C_LEGB : C_CLRC, 8'h00);
            set = (hop != 0) || (cop == 3 && v == 1);
            clr = (cop == RD) || (cop == WR) || (cop == 3 && v == 0);
            exp = set ? 1'b1 : (clr ? 1'b0 : init[0]);
            cur_stat(s);
            check((cop == 3) ? "R7 legacy cmd flag" : "R8 cmd flag set wins", s & 8'h01, {7'b0, exp});
          end

    // R10 reset level
    hcyc(WR, H_CTL, 8'h80);
    check("R10 rst high", {7'b0, cp_rst}, 8'h01);
    hcyc(NONE, 8'h00, 8'h00);
    hcyc(WR, H_CMD, 8'h00);
    check("R10 rst held", {7'b0, cp_rst}, 8'h01);
    hcyc(WR, H_CTL, 8'h00);
    check("R10 rst low", {7'b0, cp_rst}, 8'h00);

    // R11 NMI pulse
    hcyc(WR, H_CTL, 8'h40);
    check("R11 nmi pulse", {7'b0, cp_nmi}, 8'h01);
    check("R11 no led change", {7'b0, led}, 8'h01);
    hcyc(NONE, 8'h00, 8'h00);
    check("R11 nmi one cycle", {7'b0, cp_nmi}, 8'h00);
    hcyc(WR, H_CTL, 8'h9F);
    check("R11 no nmi without bit", {7'b0, cp_nmi}, 8'h00);
    hcyc(WR, H_CTL, 8'h00);

    // R12 LED
    hcyc(WR, H_CTL, 8'h20);
    check("R12 toggle off", {7'b0, led}, 8'h00);
    hcyc(WR, H_CTL, 8'h20);
    check("R12 toggle on", {7'b0, led}, 8'h01);
    ccyc(WR, C_CMD_LED, 8'hFF);
    check("R12 copro off", {7'b0, led}, 8'h00);
    ccyc(WR, C_CMD_LED, 8'hFE);
    check("R12 copro on", {7'b0, led}, 8'h01);
    cyc(WR, H_CTL, 8'h20, WR, C_CMD_LED, 8'h00);
    check("R12 copro wins", {7'b0, led}, 8'h01);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule